// File: doc/BRIEF.md
# Cascadable Dual Quadrature Counter

This block decodes incremental-encoder phase signals into position counts. It holds two 16-bit counters. Each counter follows a pair of phase inputs in x4 mode, so every edge on either phase moves the count by one. Each edge also records the counting direction. The first channel always listens to pins A/B. The second channel listens to pins C/D or to pins A/B, as a select bit chooses. Each channel has an enable and a ceiling value. Counting up past the ceiling wraps to zero, and counting down from zero reloads the ceiling.

A cascade bit fuses the two channels into one 32-bit counter. In that mode channel 1 holds the upper half and channel 2 holds the lower half. Only the second channel's phase inputs and enable drive the fused count, and a carry or borrow out of the low half steps the high half. A small synchronous register port reads and writes the control word, the ceilings, the three count views and a status word. Any access to a count view that the current mode does not offer is refused with an error flag, and a refused write changes nothing.

Top module: `quad_counter`

## Requirements
- R1: After reset both counts read 0, both ceilings read 0xFFFF, the status word reads 0, and the control word (address 0) reads 0x8. Its fields are: bit0 channel 1 enable, bit1 channel 2 enable, bit2 cascade, bit3 channel 2 input select.
- R2: The phase state is {A,B}. The steps 00→10→11→01→00 each count up by one and clear the channel's direction bit. The reverse steps each count down by one and set that bit. A pin change shows in the count three clock edges later. Direction bits sit in status bits 0 and 1.
- R3: A change of both phase bits at once leaves the count and the direction unchanged. It sets a sticky flag in status bit 2 (channel 1) or bit 3 (channel 2). Writing a 1 to that bit of the status word (address 6) clears the flag.
- R4: A channel whose enable bit is 0 does not count.
- R5: Channel 1 always follows pins A/B. Channel 2 follows pins C/D when the select bit is 1 and pins A/B when it is 0.
- R6: Counting up from the ceiling gives 0. Counting down from 0 loads the ceiling. The ceilings are at address 1 (channel 1) and address 2 (channel 2).
- R7: With cascade set, the count at address 5 reads {channel 1, channel 2}. It steps from channel 2's decoder when channel 2's enable bit is set. It wraps against the ceiling {ceiling 1, ceiling 2}, and carries and borrows cross the 16-bit boundary.
- R8: In cascade mode an access to address 3 or 4 (the channel 1 and channel 2 counts) asserts reg_err. In split mode an access to address 5 does the same, and so does an access to an unmapped address. A refused access reads 0 and writes nothing.
- R9: A count write takes effect at the next clock edge. It wins over a phase step that lands on that same edge.
- R10: Changing the cascade bit or the input select keeps the stored counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | Phase A of pin pair A/B |
| pin_b | input | 1 | Phase B of pin pair A/B |
| pin_c | input | 1 | Phase A of pin pair C/D |
| pin_d | input | 1 | Phase B of pin pair C/D |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| reg_err | output | 1 | Access refused in the current mode or unmapped |

## Verification
A wrong decoder state, such as a stale previous phase, shows as a count that is off by one or moves the wrong way. It is visible in the first count read after the edge, three clocks after the pin change. A wrong mode or select register shows at once, through a refused count access or through one channel following the wrong pin pair. A broken carry path only appears when the low half crosses 0xFFFF or 0, so the bench drives the fused count across that boundary in both directions.

// File: rtl/qc_pkg.sv
package qc_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_CEIL1 = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_CEIL2 = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_CNT1  = 4'd3;
    localparam logic [ADDR_W-1:0] ADDR_CNT2  = 4'd4;
    localparam logic [ADDR_W-1:0] ADDR_CNT32 = 4'd5;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 4'd6;

    // control word, bit3 down to bit0
    typedef struct packed {
        logic sel_cd;
        logic cascade;
        logic en2;
        logic en1;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{sel_cd: 1'b1, cascade: 1'b0, en2: 1'b0, en1: 1'b0};

    typedef struct packed {
        logic step;
        logic down;
        logic bad;
    } qstep_t;

    // phase state is {A,B}; A leading B walks 00->10->11->01->00
    function automatic qstep_t phase_decode(input logic [1:0] prev, input logic [1:0] cur);
        qstep_t r;
        logic fwd;
        r = '0;
        fwd = (prev == 2'b00 && cur == 2'b10) || (prev == 2'b10 && cur == 2'b11) ||
              (prev == 2'b11 && cur == 2'b01) || (prev == 2'b01 && cur == 2'b00);
        if (prev != cur) begin
            if ((prev ^ cur) == 2'b11) begin
                r.bad = 1'b1;
            end else begin
                r.step = 1'b1;
                r.down = !fwd;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/qc_decoder.sv
module qc_decoder
    import qc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ph_a,
    input  logic   ph_b,
    output qstep_t evt
);
    logic [SYNC_STAGES-1:0] sync_a, sync_b;
    logic [1:0]             prev_q;
    logic [1:0]             cur;

    assign cur = {sync_a[SYNC_STAGES-1], sync_b[SYNC_STAGES-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= '0;
            sync_b <= '0;
            prev_q <= 2'b00;
        end else begin
            sync_a <= {sync_a[SYNC_STAGES-2:0], ph_a};
            sync_b <= {sync_b[SYNC_STAGES-2:0], ph_b};
            prev_q <= cur;
        end
    end

    assign evt = phase_decode(prev_q, cur);
endmodule

// File: rtl/qc_core.sv
module qc_core
    import qc_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cascade,
    input  logic [1:0]             en,
    input  qstep_t [1:0]           st,
    input  logic [1:0][HALF_W-1:0] ceil,
    input  logic [1:0]             wr_half,
    input  logic                   wr_full,
    input  logic [2*HALF_W-1:0]    wdata,
    output logic [1:0][HALF_W-1:0] cnt,
    output logic [1:0]             dir
);
    localparam int FULL_W = 2 * HALF_W;
    localparam logic [HALF_W-1:0] ONE_H = 1;
    localparam logic [FULL_W-1:0] ONE_F = 1;

    function automatic logic [HALF_W-1:0] adv_h(input logic [HALF_W-1:0] v,
                                                input logic [HALF_W-1:0] c, input logic dn);
        if (dn) return (v == '0) ? c : v - ONE_H;
        return (v == c) ? '0 : v + ONE_H;
    endfunction

    function automatic logic [FULL_W-1:0] adv_f(input logic [FULL_W-1:0] v,
                                                input logic [FULL_W-1:0] c, input logic dn);
        if (dn) return (v == '0) ? c : v - ONE_F;
        return (v == c) ? '0 : v + ONE_F;
    endfunction

    logic [1:0][HALF_W-1:0] cnt_q;
    logic [1:0]             dir_q;
    logic [1:0][HALF_W-1:0] nxt_half;
    logic [FULL_W-1:0]      nxt_full;

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            nxt_half[i] = adv_h(cnt_q[i], ceil[i], st[i].down);
        end
        nxt_full = adv_f({cnt_q[0], cnt_q[1]}, {ceil[0], ceil[1]}, st[1].down);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= '0;
        end else if (cascade) begin
            if (wr_full) begin
                {cnt_q[0], cnt_q[1]} <= wdata;
            end else if (en[1] && st[1].step) begin
                {cnt_q[0], cnt_q[1]} <= nxt_full;
                dir_q[1] <= st[1].down;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (wr_half[i]) begin
                    cnt_q[i] <= wdata[HALF_W-1:0];
                end else if (en[i] && st[i].step) begin
                    cnt_q[i] <= nxt_half[i];
                    dir_q[i] <= st[i].down;
                end
            end
        end
    end

    assign cnt = cnt_q;
    assign dir = dir_q;
endmodule

// File: rtl/quad_counter.sv
module quad_counter
    import qc_pkg::*;
#(
    parameter int HALF_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_a,
    input  logic                pin_b,
    input  logic                pin_c,
    input  logic                pin_d,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [2*HALF_W-1:0] reg_wdata,
    output logic [2*HALF_W-1:0] reg_rdata,
    output logic                reg_err
);
    localparam int FULL_W = 2 * HALF_W;
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t                  ctrl_q;
    logic [1:0][HALF_W-1:0] ceil_q;
    logic [1:0]             sticky_q;
    logic [1:0]             in_a, in_b;
    qstep_t [1:0]           st;
    logic [1:0][HALF_W-1:0] cnt_w;
    logic [1:0]             dir_w;
    logic                   avail;
    logic                   wr_ok;

    assign in_a[0] = pin_a;
    assign in_b[0] = pin_b;
    assign in_a[1] = ctrl_q.sel_cd ? pin_c : pin_a;
    assign in_b[1] = ctrl_q.sel_cd ? pin_d : pin_b;

    for (genvar g = 0; g < 2; g++) begin : g_dec
        qc_decoder #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
            .clk  (clk),
            .rst  (rst),
            .ph_a (in_a[g]),
            .ph_b (in_b[g]),
            .evt  (st[g])
        );
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL, ADDR_CEIL1, ADDR_CEIL2, ADDR_STAT: avail = 1'b1;
            ADDR_CNT1, ADDR_CNT2:                         avail = !ctrl_q.cascade;
            ADDR_CNT32:                                   avail = ctrl_q.cascade;
            default:                                      avail = 1'b0;
        endcase
    end

    assign reg_err = (reg_rd || reg_wr) && !avail;
    assign wr_ok   = reg_wr && avail;

    always_comb begin
        reg_rdata = '0;
        if (reg_rd && avail) begin
            case (reg_addr)
                ADDR_CTRL:  reg_rdata = {{(FULL_W-CTRL_W){1'b0}}, ctrl_q};
                ADDR_CEIL1: reg_rdata = {{HALF_W{1'b0}}, ceil_q[0]};
                ADDR_CEIL2: reg_rdata = {{HALF_W{1'b0}}, ceil_q[1]};
                ADDR_CNT1:  reg_rdata = {{HALF_W{1'b0}}, cnt_w[0]};
                ADDR_CNT2:  reg_rdata = {{HALF_W{1'b0}}, cnt_w[1]};
                ADDR_CNT32: reg_rdata = {cnt_w[0], cnt_w[1]};
                ADDR_STAT:  reg_rdata = {{(FULL_W-4){1'b0}}, sticky_q, dir_w};
                default:    reg_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RESET;
            ceil_q   <= '1;
            sticky_q <= '0;
        end else begin
            if (wr_ok && reg_addr == ADDR_CTRL)  ctrl_q    <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (wr_ok && reg_addr == ADDR_CEIL1) ceil_q[0] <= reg_wdata[HALF_W-1:0];
            if (wr_ok && reg_addr == ADDR_CEIL2) ceil_q[1] <= reg_wdata[HALF_W-1:0];
            for (int i = 0; i < 2; i++) begin
                sticky_q[i] <= (sticky_q[i] && !(wr_ok && reg_addr == ADDR_STAT && reg_wdata[2+i]))
                               || st[i].bad;
            end
        end
    end

    qc_core #(.HALF_W(HALF_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .cascade (ctrl_q.cascade),
        .en      ({ctrl_q.en2, ctrl_q.en1}),
        .st      (st),
        .ceil    (ceil_q),
        .wr_half ({wr_ok && reg_addr == ADDR_CNT2, wr_ok && reg_addr == ADDR_CNT1}),
        .wr_full (wr_ok && reg_addr == ADDR_CNT32),
        .wdata   (reg_wdata),
        .cnt     (cnt_w),
        .dir     (dir_w)
    );
endmodule

// File: rtl/qc_checker.sv
module qc_checker
    import qc_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   reg_wr,
    input logic                   reg_rd,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [2*HALF_W-1:0]    reg_wdata,
    input logic                   reg_err,
    input logic                   cascade,
    input logic [1:0]             en,
    input logic [1:0][HALF_W-1:0] cnt,
    input logic [1:0][HALF_W-1:0] ceil,
    input qstep_t [1:0]           st,
    input logic [1:0]             sticky
);
    // R8
    cnt32_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADDR_CNT32 && !cascade) |-> reg_err);

    // R8
    half_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_CNT1 && cascade) |-> reg_err);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cascade && !en[0] && !(reg_wr && reg_addr == ADDR_CNT1)) |=> cnt[0] == $past(cnt[0]));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sticky[0] && !(reg_wr && reg_addr == ADDR_STAT && reg_wdata[2])) |=> sticky[0]);

    // R9
    cnt_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_CNT2 && !cascade) |=> cnt[1] == $past(reg_wdata[HALF_W-1:0]));

    // R6
    wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!cascade && en[1] && st[1].step && !st[1].down && cnt[1] == ceil[1]
         && !(reg_wr && reg_addr == ADDR_CNT2)) |=> cnt[1] == '0);

    // R6
    wrap_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (!cascade && en[1] && st[1].step && st[1].down && cnt[1] == '0
         && !(reg_wr && reg_addr == ADDR_CNT2)) |=> cnt[1] == $past(ceil[1]));

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!cascade && en[0] && st[0].step && !st[0].down && cnt[0] != ceil[0]
         && !(reg_wr && reg_addr == ADDR_CNT1)) |=> cnt[0] == $past(cnt[0]) + 1'b1);

    // R7
    casc_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (cascade && en[1] && st[1].step && !st[1].down && {cnt[0], cnt[1]} != {ceil[0], ceil[1]}
         && !(reg_wr && reg_addr == ADDR_CNT32))
        |=> {cnt[0], cnt[1]} == $past({cnt[0], cnt[1]}) + 1'b1);
endmodule

bind quad_counter qc_checker #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_err   (reg_err),
    .cascade   (ctrl_q.cascade),
    .en        ({ctrl_q.en2, ctrl_q.en1}),
    .cnt       (cnt_w),
    .ceil      (ceil_q),
    .st        (st),
    .sticky    (sticky_q)
);

// File: tb/quad_counter_tb.sv
module quad_counter_tb;
    import qc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_a = 1'b0, pin_b = 1'b0, pin_c = 1'b0, pin_d = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    quad_counter u_dut (
        .clk(clk), .rst(rst),
        .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c), .pin_d(pin_d),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err)
    );

    function automatic logic [1:0] fwd(input logic [1:0] s);
        case (s)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] bwd(input logic [1:0] s);
        case (s)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    // monitor: pops expected items and compares against read results
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (reg_rd) begin
                exp_t e;
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard underflow: actual %h", reg_rdata);
                end else begin
                    e = sb_q.pop_front();
                    if (reg_rdata !== e.data || reg_err !== e.err) begin
                        errors++;
                        $display("FAIL %s: actual data %h err %b, expected data %h err %b",
                                 e.tag, reg_rdata, reg_err, e.data, e.err);
                    end
                end
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [31:0] d, input logic e, input string tag);
        @(negedge clk);
        reg_rd = 1'b1;
        reg_addr = a;
        sb_q.push_back('{data: d, err: e, tag: tag});
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic e, input string tag);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        #2;
        checks++;
        if (reg_err !== e) begin
            errors++;
            $display("FAIL %s: write err actual %b expected %b", tag, reg_err, e);
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic move_ab(input bit up);
        @(negedge clk);
        {pin_a, pin_b} = up ? fwd({pin_a, pin_b}) : bwd({pin_a, pin_b});
        repeat (4) @(negedge clk);
    endtask

    task automatic move_cd(input bit up);
        @(negedge clk);
        {pin_c, pin_d} = up ? fwd({pin_c, pin_d}) : bwd({pin_c, pin_d});
        repeat (4) @(negedge clk);
    endtask

    // step lands on the third edge after the pin change; the write is on that same edge
    task automatic move_cd_with_write(input logic [31:0] d);
        @(negedge clk);
        {pin_c, pin_d} = fwd({pin_c, pin_d});
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = ADDR_CNT2;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #2ms;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(ADDR_CTRL,  32'h8,    1'b0, "R1 ctrl");
        rd(ADDR_CEIL1, 32'hFFFF, 1'b0, "R1 ceil1");
        rd(ADDR_CEIL2, 32'hFFFF, 1'b0, "R1 ceil2");
        rd(ADDR_CNT1,  32'h0,    1'b0, "R1 cnt1");
        rd(ADDR_CNT2,  32'h0,    1'b0, "R1 cnt2");
        rd(ADDR_STAT,  32'h0,    1'b0, "R1 status");
        // R8 refused in split mode, unmapped address
        rd(ADDR_CNT32, 32'h0,    1'b1, "R8 cnt32 split");
        rd(4'd7,       32'h0,    1'b1, "R8 unmapped");

        wr(ADDR_CTRL,  32'hB,  1'b0, "R5 ctrl");
        wr(ADDR_CEIL2, 32'd100, 1'b0, "R6 ceil2");

        // R2 up count on A/B, R5 channel 2 on C/D ignores it
        for (int i = 0; i < 4; i++) move_ab(1'b1);
        rd(ADDR_CNT1, 32'd4, 1'b0, "R2 up four");
        rd(ADDR_CNT2, 32'd0, 1'b0, "R5 ch2 ignores A/B");
        rd(ADDR_STAT, 32'h0, 1'b0, "R2 dir up");

        // R6 down from zero loads ceiling, R2 direction bit
        move_cd(1'b0);
        rd(ADDR_CNT2, 32'd100, 1'b0, "R6 down reload");
        rd(ADDR_STAT, 32'h2,   1'b0, "R2 dir down");
        move_cd(1'b1);
        rd(ADDR_CNT2, 32'd0,   1'b0, "R6 up wrap at 100");

        wr(ADDR_CEIL1, 32'd5, 1'b0, "R6 ceil1");
        move_ab(1'b1);
        rd(ADDR_CNT1, 32'd5, 1'b0, "R6 reach ceiling");
        move_ab(1'b1);
        rd(ADDR_CNT1, 32'd0, 1'b0, "R6 wrap to zero");

        // R3 illegal jump 11 -> 00
        @(negedge clk);
        {pin_a, pin_b} = 2'b00;
        repeat (4) @(negedge clk);
        rd(ADDR_CNT1, 32'd0, 1'b0, "R3 count held");
        rd(ADDR_STAT, 32'h4, 1'b0, "R3 flag set");
        wr(ADDR_STAT, 32'h4, 1'b0, "R3 clear");
        rd(ADDR_STAT, 32'h0, 1'b0, "R3 flag cleared");

        // R4 disabled channel
        wr(ADDR_CTRL, 32'hA, 1'b0, "R4 ctrl");
        move_ab(1'b1);
        rd(ADDR_CNT1, 32'd0, 1'b0, "R4 no count when disabled");
        wr(ADDR_CTRL, 32'hB, 1'b0, "R4 ctrl back");
        move_ab(1'b0);
        rd(ADDR_CNT1, 32'd5, 1'b0, "R6 down reload ch1");

        // R5 select 0: channel 2 follows A/B
        wr(ADDR_CTRL, 32'h3, 1'b0, "R5 ctrl sel0");
        move_ab(1'b1);
        rd(ADDR_CNT1, 32'd0, 1'b0, "R5 ch1 wraps");
        rd(ADDR_CNT2, 32'd1, 1'b0, "R5 ch2 follows A/B");
        move_cd(1'b1);
        rd(ADDR_CNT2, 32'd1, 1'b0, "R5 ch2 ignores C/D");
        move_cd(1'b0);
        move_ab(1'b0);
        rd(ADDR_CNT2, 32'd0, 1'b0, "R5 ch2 down on A/B");
        wr(ADDR_CTRL, 32'hB, 1'b0, "R5 ctrl sel1");

        // R9 write, then write colliding with a step
        wr(ADDR_CNT1, 32'd3, 1'b0, "R9 write");
        rd(ADDR_CNT1, 32'd3, 1'b0, "R9 write visible");
        move_cd_with_write(32'h33);
        rd(ADDR_CNT2, 32'h33, 1'b0, "R9 write beats step");

        // R7 cascade with carry and borrow
        wr(ADDR_CEIL1, 32'hFFFF, 1'b0, "R7 ceil1");
        wr(ADDR_CEIL2, 32'hFFFF, 1'b0, "R7 ceil2");
        wr(ADDR_CNT1,  32'h2,    1'b0, "R7 cnt1");
        wr(ADDR_CNT2,  32'hFFFF, 1'b0, "R7 cnt2");
        wr(ADDR_CTRL,  32'hE,    1'b0, "R7 ctrl cascade");
        rd(ADDR_CNT32, 32'h0002FFFF, 1'b0, "R10 counts kept into cascade");
        rd(ADDR_CNT1,  32'h0,        1'b1, "R8 cnt1 cascade");
        move_cd(1'b1);
        rd(ADDR_CNT32, 32'h00030000, 1'b0, "R7 carry");
        move_cd(1'b0);
        rd(ADDR_CNT32, 32'h0002FFFF, 1'b0, "R7 borrow");
        wr(ADDR_CNT2, 32'h5, 1'b1, "R8 write refused");
        rd(ADDR_CNT32, 32'h0002FFFF, 1'b0, "R8 refused write no effect");
        wr(ADDR_CNT32, 32'h0, 1'b0, "R7 cnt32 write");
        move_cd(1'b0);
        rd(ADDR_CNT32, 32'hFFFFFFFF, 1'b0, "R7 reload full ceiling");
        rd(ADDR_STAT,  32'h3,        1'b0, "R7 direction");

        // R10 back to split
        wr(ADDR_CTRL, 32'hB, 1'b0, "R10 ctrl split");
        rd(ADDR_CNT1, 32'hFFFF, 1'b0, "R10 cnt1 kept");
        rd(ADDR_CNT2, 32'hFFFF, 1'b0, "R10 cnt2 kept");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule